// File: doc/BRIEF.md
# Pipelined Memory-Mapped Read Agent

This block is a synchronous read-only agent on a memory-mapped port. A host starts a read by raising `host_read` with an address on `host_addr`. The agent may hold that request off with `agent_wait` for a fixed number of wait-state cycles. The request counts as accepted on the cycle where `host_read` is high and `agent_wait` is low. After acceptance, the word looked up from a small internal register array travels down a fixed-length delay line. It appears on `resp_data`, qualified by a one-cycle `resp_valid` pulse, a fixed number of cycles later.

Acceptance and data return are separate, so a new request can be taken while earlier ones are still in flight. With no wait-states the agent takes one read per cycle, and the data comes back one word per cycle after the initial latency. The wait-state count and the latency are elaboration parameters, and the two can be combined freely.

The address-phase controller is a two-state machine. In `ST_READY` no request is being held off. A read seen in `ST_READY` takes the transition READY→STRETCH, which loads the wait counter with one. In `ST_STRETCH` the counter advances on each held cycle. Once the counter reaches the wait-state count, the STRETCH→READY transition accepts the read. STRETCH→READY is also taken when the host drops the read, which abandons the request. When the wait-state count is zero the machine is not built, and every read is accepted at once.

Top module: `pmr_agent`

## Requirements
- R1: A read is accepted exactly on a cycle where `host_read` is 1 and `agent_wait` is 0. While `agent_wait` is 1, the host keeps `host_read` high and `host_addr` unchanged.
- R2: With WAIT_STATES = W > 0, a continuously held read sees `agent_wait` = 1 for its first W cycles and is accepted on cycle W+1. Back-to-back held reads are accepted once every W+1 cycles.
- R3: `agent_wait` is 1 only in cycles where `host_read` is 1.
- R4: With WAIT_STATES = 0, `agent_wait` stays 0 and one read is accepted in every cycle that `host_read` is 1.
- R5: The data for a read accepted in cycle a appears with `resp_valid` = 1 in cycle a + LATENCY (LATENCY ≥ 1), whatever the wait-state count was.
- R6: `resp_valid` pulses for exactly one cycle per accepted read, and responses come back strictly in acceptance order. No more than LATENCY reads are ever in flight.
- R7: The word returned for address a is the low DATA_W bits of ((a × 0x9E3779B1) XOR 0xA5A50000), computed modulo 2^32.
- R8: A synchronous reset `rst` clears all in-flight entries and the wait counter. No `resp_valid` appears after reset for reads accepted before it, and the first read after reset is again held off for the full W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_read | input | 1 | Read request from the host |
| host_addr | input | ADDR_W | Read address, held while stalled |
| agent_wait | output | 1 | Hold-off: request not yet accepted |
| resp_valid | output | 1 | One-cycle marker of returned data |
| resp_data | output | DATA_W | Returned read word |

## Verification
The `agent_wait` response is combinational, so the bench reads it shortly after driving each request cycle. It expects a high value for the first W cycles of each request and a low value on cycle W+1. The bench records the cycle index of every acceptance, together with the word the formula predicts for that address. The matching `resp_valid` is due exactly LATENCY cycles later. The monitor therefore compares, on every cycle, the head of its queue against the registered outputs: it expects a pulse only when the head entry's due cycle equals the current cycle, and silence otherwise. For the reset cases, entries that were due after the reset edge are discarded, and the following cycles must show no pulse at all.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    typedef enum logic [0:0] {
        ST_READY   = 1'b0,
        ST_STRETCH = 1'b1
    } wait_state_t;

    // Fixed content pattern of the register array, 32 bits per entry.
    function automatic logic [31:0] pmr_word(input int unsigned idx);
        logic [31:0] prod;
        prod = 32'(idx) * 32'h9E37_79B1;
        return prod ^ 32'hA5A5_0000;
    endfunction

endpackage

// File: rtl/pmr_waitgen.sv
module pmr_waitgen
    import pmr_pkg::*;
#(
    parameter int WAIT_STATES = 1,
    parameter int ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_read,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              agent_wait,
    output logic              accept
);

    generate
        if (WAIT_STATES == 0) begin : g_nowait
            always_comb begin
                agent_wait = 1'b0;
                accept     = host_read;
            end
        end else begin : g_wait
            localparam int CW = $clog2(WAIT_STATES + 1);
            localparam logic [CW-1:0] LAST = CW'(WAIT_STATES);

            wait_state_t    state, state_nxt;
            logic [CW-1:0]  cnt, cnt_nxt;

            // State register
            always_ff @(posedge clk) begin
                if (rst) begin
                    state <= ST_READY;
                    cnt   <= '0;
                end else begin
                    state <= state_nxt;
                    cnt   <= cnt_nxt;
                end
            end

            // Next-state logic
            always_comb begin
                state_nxt = state;
                cnt_nxt   = cnt;
                unique case (state)
                    ST_READY: begin
                        if (host_read) begin
                            state_nxt = ST_STRETCH;
                            cnt_nxt   = CW'(1);
                        end
                    end
                    ST_STRETCH: begin
                        if (!host_read || cnt == LAST) begin
                            state_nxt = ST_READY;
                            cnt_nxt   = '0;
                        end else begin
                            cnt_nxt = cnt + CW'(1);
                        end
                    end
                    default: begin
                        state_nxt = ST_READY;
                        cnt_nxt   = '0;
                    end
                endcase
            end

            // Output logic
            always_comb begin
                agent_wait = 1'b0;
                unique case (state)
                    ST_READY:   agent_wait = host_read;
                    ST_STRETCH: agent_wait = host_read && (cnt != LAST);
                    default:    agent_wait = host_read;
                endcase
                accept = host_read && !agent_wait;
            end

            // R2: two acceptances are never adjacent when wait-states exist
            a_r2_accept_spacing: assert property (@(posedge clk) disable iff (rst)
                accept |=> !accept);

            // R1: host holds request and address while stalled
            a_r1_host_holds: assert property (@(posedge clk) disable iff (rst)
                (host_read && agent_wait) |=> (host_read && $stable(host_addr)));
        end
    endgenerate

    // R3: hold-off only with a pending request
    a_r3_wait_needs_read: assert property (@(posedge clk) disable iff (rst)
        agent_wait |-> host_read);

endmodule

// File: rtl/pmr_regfile.sv
module pmr_regfile
    import pmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            localparam logic [31:0] INIT = pmr_word(i);
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[i] <= DATA_W'(INIT);
                end
            end
        end
    endgenerate

    always_comb rd_data = regs[rd_addr];

endmodule

// File: rtl/pmr_delay.sv
module pmr_delay #(
    parameter int LATENCY = 3,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic              stg_v [LATENCY];
    logic [DATA_W-1:0] stg_d [LATENCY];

    generate
        for (genvar s = 0; s < LATENCY; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stg_v[s] <= 1'b0;
                        stg_d[s] <= '0;
                    end else begin
                        stg_v[s] <= in_valid;
                        stg_d[s] <= in_data;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stg_v[s] <= 1'b0;
                        stg_d[s] <= '0;
                    end else begin
                        stg_v[s] <= stg_v[s-1];
                        stg_d[s] <= stg_d[s-1];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        out_valid = stg_v[LATENCY-1];
        out_data  = stg_d[LATENCY-1];
    end

    // R8: the first cycle after reset shows no returned word
    a_r8_flush: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

endmodule

// File: rtl/pmr_agent.sv
module pmr_agent #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int WAIT_STATES = 1,
    parameter int LATENCY     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_read,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              agent_wait,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data
);

    localparam int OW = $clog2(LATENCY + 2);

    logic              accept;
    logic [DATA_W-1:0] lookup;

    pmr_waitgen #(
        .WAIT_STATES(WAIT_STATES),
        .ADDR_W     (ADDR_W)
    ) u_waitgen (
        .clk       (clk),
        .rst       (rst),
        .host_read (host_read),
        .host_addr (host_addr),
        .agent_wait(agent_wait),
        .accept    (accept)
    );

    pmr_regfile #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regfile (
        .clk    (clk),
        .rst    (rst),
        .rd_addr(host_addr),
        .rd_data(lookup)
    );

    pmr_delay #(
        .LATENCY(LATENCY),
        .DATA_W (DATA_W)
    ) u_delay (
        .clk      (clk),
        .rst      (rst),
        .in_valid (accept),
        .in_data  (lookup),
        .out_valid(resp_valid),
        .out_data (resp_data)
    );

    // Count of reads accepted but not yet returned, for the checks below.
    logic [OW-1:0] inflight;
    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + OW'(accept) - OW'(resp_valid);
        end
    end

    // R6: in-flight reads never exceed the delay line depth
    a_r6_inflight_bound: assert property (@(posedge clk) disable iff (rst)
        inflight <= OW'(LATENCY));

    // R6: every returned word belongs to an accepted read
    a_r6_valid_has_request: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (inflight != '0));

    // R4: no hold-off in the zero wait-state variant
    a_r4_no_hold: assert property (@(posedge clk) disable iff (rst)
        (WAIT_STATES == 0) |-> !agent_wait);

endmodule

// File: tb/pmr_agent_bench.sv
module pmr_agent_bench;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;
    localparam int W0 = 1, L0 = 3;
    localparam int W1 = 0, L1 = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd0 = 1'b0, rd1 = 1'b0;
    logic [AW-1:0] ad0 = '0, ad1 = '0;
    logic wt0, wt1, vl0, vl1;
    logic [DW-1:0] dt0, dt1;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    logic [63:0] q0 [$];
    logic [63:0] q1 [$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pmr_agent #(.ADDR_W(AW), .DATA_W(DW), .WAIT_STATES(W0), .LATENCY(L0)) u_pmr_agent (
        .clk(clk), .rst(rst), .host_read(rd0), .host_addr(ad0),
        .agent_wait(wt0), .resp_valid(vl0), .resp_data(dt0));

    pmr_agent #(.ADDR_W(AW), .DATA_W(DW), .WAIT_STATES(W1), .LATENCY(L1)) u_pmr_agent_w0 (
        .clk(clk), .rst(rst), .host_read(rd1), .host_addr(ad1),
        .agent_wait(wt1), .resp_valid(vl1), .resp_data(dt1));

    function automatic logic [31:0] exp_word(input int a);
        logic [31:0] p;
        p = 32'(a) * 32'h9E37_79B1;
        return p ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic set_read(input int d, input logic r, input int a);
        if (d == 0) begin rd0 = r; ad0 = AW'(a); end
        else        begin rd1 = r; ad1 = AW'(a); end
    endtask

    // Driver: issue n reads, check hold-off per R1/R2/R3/R4, push expected results.
    task automatic run_reads(input int d, input int n, input int a0,
                             input int stride, input int gap);
        int w, l, first_acc, last_acc;
        w = (d == 0) ? W0 : W1;
        l = (d == 0) ? L0 : L1;
        first_acc = 0;
        last_acc = 0;
        for (int i = 0; i < n; i++) begin
            int addr;
            addr = (a0 + i * stride) % DEPTH;
            set_read(d, 1'b1, addr);
            for (int k = 0; ; k++) begin
                logic wv;
                #2;
                wv = (d == 0) ? wt0 : wt1;
                if (k < w) begin
                    chk(wv == 1'b1, "R2", "hold-off during stretch", longint'(wv), 1);
                    @(negedge clk);
                end else begin
                    chk(wv == 1'b0, (w == 0) ? "R4" : "R1", "accept cycle", longint'(wv), 0);
                    if (i == 0) first_acc = cyc;
                    last_acc = cyc;
                    if (d == 0) q0.push_back({32'(cyc + l), exp_word(addr)});
                    else        q1.push_back({32'(cyc + l), exp_word(addr)});
                    break;
                end
            end
            @(negedge clk);
            if (gap > 0) begin
                set_read(d, 1'b0, 0);
                for (int g = 0; g < gap; g++) begin
                    #2;
                    chk(((d == 0) ? wt0 : wt1) == 1'b0, "R3", "idle hold-off",
                        longint'((d == 0) ? wt0 : wt1), 0);
                    @(negedge clk);
                end
            end
        end
        set_read(d, 1'b0, 0);
        if (gap == 0 && n > 1)
            chk((last_acc - first_acc) == (n - 1) * (w + 1), (w == 0) ? "R4" : "R2",
                "throughput span", last_acc - first_acc, (n - 1) * (w + 1));
    endtask

    // Monitors: R5 timing, R6 order and single pulse, R7 content.
    initial forever begin
        @(negedge clk);
        #1;
        if (q0.size() > 0 && int'(q0[0][63:32]) == cyc) begin
            chk(vl0 == 1'b1, "R5", "dut0 valid due", longint'(vl0), 1);
            chk(dt0 == q0[0][31:0], "R7", "dut0 data", dt0, q0[0][31:0]);
            void'(q0.pop_front());
        end else begin
            chk(vl0 == 1'b0, "R6", "dut0 no stray valid", longint'(vl0), 0);
        end
    end

    initial forever begin
        @(negedge clk);
        #1;
        if (q1.size() > 0 && int'(q1[0][63:32]) == cyc) begin
            chk(vl1 == 1'b1, "R5", "dut1 valid due", longint'(vl1), 1);
            chk(dt1 == q1[0][31:0], "R7", "dut1 data", dt1, q1[0][31:0]);
            void'(q1.pop_front());
        end else begin
            chk(vl1 == 1'b0, "R6", "dut1 no stray valid", longint'(vl1), 0);
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R8: reset state
        chk(vl0 == 1'b0 && vl1 == 1'b0, "R8", "valid in reset", longint'({vl0, vl1}), 0);
        chk(wt0 == 1'b0 && wt1 == 1'b0, "R8", "wait in reset", longint'({wt0, wt1}), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: back-to-back with one wait-state
        run_reads(0, 6, 0, 1, 0);
        // R4: one per cycle with zero wait-states
        run_reads(1, 8, 3, 5, 0);
        // Mixed patterns with idle gaps, both ports concurrently
        fork
            run_reads(0, 5, 2, 3, 1);
            run_reads(1, 6, 15, 7, 2);
        join
        // Address wrap boundary 15 -> 0
        run_reads(1, 2, 15, 1, 0);
        run_reads(0, 2, 15, 1, 0);
        repeat (6) @(negedge clk);

        // R8: reset with reads in flight
        run_reads(0, 3, 9, 2, 0);
        rst = 1'b1;
        #2;
        while (q0.size() > 0 && int'(q0[q0.size()-1][63:32]) > cyc) void'(q0.pop_back());
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (L0 + 3) @(negedge clk);

        // R8: wait counter cleared by reset while a request is stretched
        set_read(0, 1'b1, 7);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_reads(0, 2, 7, 1, 0);

        repeat (8) @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R6", "all responses returned",
            q0.size() + q1.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule